// File: doc/BRIEF.md
# DRAM Clock-Stop Controller

This block sits between a memory command scheduler and the memory device pins. It produces the differential memory clock, half the rate of the system clock, and passes the scheduler's commands through. It can park that clock during idle periods to save power.

A stop request from the power manager is honoured only when three things hold. The most recent access command must have fully completed, including the read data beats still leaving the device. The timing interval tied to that command must have elapsed. The clock-enable pin must be high. When the clock is parked it rests with the true phase low and the complement high.

Dropping the stop request restarts the clock. The block then forces idle (NOP) cycles before it accepts any further command. A stall output holds the scheduler back whenever a command cannot be taken on the current clock edge.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst` is high, `mem_cmd_o` is NOP (3'd0), `ck_o` is 0, `ck_n_o` is 1 and `stall_o` is 1. After reset the memory clock runs, toggling `ck_o` on every system clock edge.
- R2: Command encoding on `cmd_i` and `mem_cmd_o`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 MODE SET, 7 reserved (no delay). A command is accepted on a system clock edge where `cmd_valid_i` is high and `stall_o` is low. Accepted commands appear on `mem_cmd_o` in order, one memory clock cycle each, and every other memory clock cycle carries NOP.
- R3: After an ACTIVE, PRECHARGE, AUTO REFRESH or MODE SET, the clock is not parked until at least T_RCD, T_RP, T_RFC or T_MRD further memory clock cycles carrying NOP have been sampled (rising `ck_o`).
- R4: For a READ the hold-off is CAS_LAT + BURST_LEN/2 NOP cycles, covering the outgoing data. For a WRITE it is T_WR + BURST_LEN/2.
- R5: While `cke_i` is low the memory clock keeps running even with `stop_req_i` high. Once `cke_i` returns high, a pending stop takes effect.
- R6: A parked clock holds `ck_o` at 0 and `ck_n_o` at 1. Parking happens only at the edge where the clock phase falls, so no shortened high pulse is produced.
- R7: Deasserting `stop_req_i` while parked restarts the clock. At least POST_NOPS NOP cycles are sampled by the memory before the next command, and `stall_o` stays high until then.
- R8: `stall_o` is high while the clock is parked and whenever `stop_req_i` is high, so no command is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Current level of the memory clock-enable pin |
| stop_req_i | input | 1 | High requests a clock stop; low requests running |
| cmd_valid_i | input | 1 | Scheduler presents a command |
| cmd_i | input | 3 | Scheduler command code |
| stall_o | output | 1 | Command cannot be taken on the next edge |
| mem_cmd_o | output | 3 | Command driven to the memory |
| ck_o | output | 1 | Memory clock, true phase |
| ck_n_o | output | 1 | Memory clock, complement phase |

## Verification
Each access type is issued alone and followed straight away by a stop request. The number of NOP cycles the memory sees before the park shows whether the per-command delay, including the read and write data tails, was loaded correctly. Every park is followed by a restart with a command already waiting, which separates a correct post-restart NOP insertion from an early acceptance. A stop request held while the clock-enable pin is low tells the clock-enable condition apart from the completion condition. A back-to-back burst of mixed commands checks ordering and the one-command-per-cycle spacing.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;
endpackage

// File: rtl/clk_stop_timer.sv
// Completion timer: loaded with the hold-off of each issued command,
// counts down once per memory clock cycle.
module clk_stop_timer #(
  parameter int T_RCD     = 3,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 12,
  parameter int T_MRD     = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       load,
  input  logic [2:0] cmd,
  output logic       busy_o
);
  import clk_stop_pkg::*;

  localparam int HALF_BL = BURST_LEN / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (cmd)
      CMD_ACT: load_val = CNT_W'(T_RCD);
      CMD_RD:  load_val = CNT_W'(CAS_LAT + HALF_BL);
      CMD_WR:  load_val = CNT_W'(T_WR + HALF_BL);
      CMD_PRE: load_val = CNT_W'(T_RP);
      CMD_REF: load_val = CNT_W'(T_RFC);
      CMD_MRS: load_val = CNT_W'(T_MRD);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      if (load) begin
        cnt_q <= load_val;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/clk_stop_park.sv
// Memory clock generator with park/restart and post-restart NOP hold.
module clk_stop_park #(
  parameter int POST_NOPS = 1,
  parameter int NOP_W     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic park_go,
  input  logic wake,
  output logic run_o,
  output logic ck_o,
  output logic ck_n_o,
  output logic hold_o
);
  logic             run_q;
  logic             ck_q;
  logic             ckn_q;
  logic [NOP_W-1:0] nop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b1;
      ck_q  <= 1'b0;
      ckn_q <= 1'b1;
      nop_q <= '0;
    end else if (run_q) begin
      ck_q  <= ~ck_q;
      ckn_q <= ck_q;
      if (ck_q) begin
        // falling phase: the only edge where the clock may be parked
        if (park_go) run_q <= 1'b0;
        if (nop_q != '0) nop_q <= nop_q - 1'b1;
      end
    end else if (wake) begin
      run_q <= 1'b1;
      nop_q <= NOP_W'(POST_NOPS);
    end
  end

  assign run_o  = run_q;
  assign ck_o   = ck_q;
  assign ck_n_o = ckn_q;
  assign hold_o = (nop_q != '0);
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int T_RCD     = 3,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 12,
  parameter int T_MRD     = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int POST_NOPS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke_i,
  input  logic       stop_req_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  output logic       stall_o,
  output logic [2:0] mem_cmd_o,
  output logic       ck_o,
  output logic       ck_n_o
);
  import clk_stop_pkg::*;

  localparam int SUM_D = T_RCD + T_WR + T_RP + T_RFC + T_MRD + CAS_LAT + BURST_LEN;
  localparam int CNT_W = $clog2(SUM_D + 1);
  localparam int NOP_W = (POST_NOPS < 1) ? 1 : $clog2(POST_NOPS + 1);

  logic run_q;
  logic busy;
  logic hold;
  logic step;
  logic accept;
  logic park_go;
  logic [2:0] mem_cmd_q;

  // step: system edge that ends a memory clock high phase
  assign step    = run_q & ck_o;
  assign stall_o = ~(step & ~hold & ~stop_req_i);
  assign accept  = cmd_valid_i & ~stall_o;
  assign park_go = stop_req_i & cke_i & ~busy;

  clk_stop_timer #(
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .step(step), .load(accept), .cmd(cmd_i), .busy_o(busy)
  );

  clk_stop_park #(
    .POST_NOPS(POST_NOPS), .NOP_W(NOP_W)
  ) u_park (
    .clk(clk), .rst(rst), .park_go(park_go), .wake(~stop_req_i),
    .run_o(run_q), .ck_o(ck_o), .ck_n_o(ck_n_o), .hold_o(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cmd_q <= CMD_NOP;
    end else if (step) begin
      mem_cmd_q <= accept ? cmd_i : CMD_NOP;
    end
  end

  assign mem_cmd_o = mem_cmd_q;
endmodule

// File: rtl/clk_stop_chk.sv
module clk_stop_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke_i,
  input logic       stop_req_i,
  input logic       ck_o,
  input logic       ck_n_o,
  input logic [2:0] mem_cmd_o,
  input logic       stall_o,
  input logic       run_q,
  input logic       busy,
  input logic       hold
);
  a_r6_park_levels: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!ck_o && ck_n_o));

  a_r6_park_low_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> !ck_o);

  a_r5_cke_keeps_clock: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cke_i) |=> run_q);

  a_r3_busy_keeps_clock: assert property (@(posedge clk) disable iff (rst)
    (run_q && busy) |=> run_q);

  a_r7_nop_on_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (mem_cmd_o == 3'd0));

  a_r8_stall_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (hold || !run_q || stop_req_i) |-> stall_o);

  a_r2_quiet_when_parked: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (mem_cmd_o == 3'd0));
endmodule

bind clk_stop_ctrl clk_stop_chk u_chk (
  .clk(clk), .rst(rst), .cke_i(cke_i), .stop_req_i(stop_req_i),
  .ck_o(ck_o), .ck_n_o(ck_n_o), .mem_cmd_o(mem_cmd_o), .stall_o(stall_o),
  .run_q(run_q), .busy(busy), .hold(hold)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int T_RCD = 3, T_WR = 2, T_RP = 3, T_RFC = 12, T_MRD = 2;
  localparam int CAS_LAT = 3, BURST_LEN = 4, POST_NOPS = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke_i = 1'b1;
  logic       stop_req_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       stall_o;
  logic [2:0] mem_cmd_o;
  logic       ck_o, ck_n_o;

  clk_stop_ctrl u_dut (
    .clk(clk), .rst(rst), .cke_i(cke_i), .stop_req_i(stop_req_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .stall_o(stall_o),
    .mem_cmd_o(mem_cmd_o), .ck_o(ck_o), .ck_n_o(ck_n_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_q[$];
  int  nops_since = 0;
  int  last_d = 0;
  int  low_run = 0;
  int  rise_cnt = 0;
  bit  parked = 1'b0;
  bit  woke_wait = 1'b0;
  bit  prev_ck = 1'b0;
  bit  last_rw = 1'b0;
  bit  done = 1'b0;

  function automatic int exp_delay(logic [2:0] c);
    case (c)
      3'd1: return T_RCD;
      3'd2: return CAS_LAT + BURST_LEN / 2;
      3'd3: return T_WR + BURST_LEN / 2;
      3'd4: return T_RP;
      3'd5: return T_RFC;
      3'd6: return T_MRD;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: samples at rising memory clock, scoreboard compare
  always @(negedge clk) begin
    if (!rst) begin
      if (ck_o) low_run = 0; else low_run++;
      if (low_run == 3) begin
        parked = 1'b1;
        if (last_rw) check(nops_since >= last_d, "R4 hold-off before park", nops_since, last_d);
        else         check(nops_since >= last_d, "R3 hold-off before park", nops_since, last_d);
        check(ck_n_o == 1'b1 && ck_o == 1'b0, "R6 parked levels", {ck_o, ck_n_o}, 1);
        check(stall_o == 1'b1, "R8 stall while parked", stall_o, 1);
        nops_since = 0;
        last_d = 0;
        last_rw = 1'b0;
        woke_wait = 1'b1;
      end
      if (ck_o && !prev_ck) begin
        parked = 1'b0;
        rise_cnt++;
        if (mem_cmd_o == 3'd0) begin
          nops_since++;
        end else begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected command", mem_cmd_o, 0);
          end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(mem_cmd_o == e, "R2 command order", mem_cmd_o, e);
          end
          if (woke_wait) check(nops_since >= POST_NOPS, "R7 NOPs after restart", nops_since, POST_NOPS);
          woke_wait = 1'b0;
          last_d = exp_delay(mem_cmd_o);
          last_rw = (mem_cmd_o == 3'd2) || (mem_cmd_o == 3'd3);
          nops_since = 0;
        end
      end
      prev_ck = ck_o;
    end
  end

  task automatic issue(logic [2:0] c);
    for (int i = 0; i < 400 && stall_o; i++) @(negedge clk);
    if (stall_o) check(1'b0, "R7 stall never released", 1, 0);
    exp_q.push_back(c);
    cmd_valid_i = 1'b1;
    cmd_i = c;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    cmd_i = 3'd0;
  endtask

  task automatic wait_park(string req);
    for (int i = 0; i < 400 && !parked; i++) @(negedge clk);
    check(parked, req, parked, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cmd_o == 3'd0, "R1 reset cmd", mem_cmd_o, 0);
    check(ck_o == 1'b0 && ck_n_o == 1'b1, "R1 reset clock levels", {ck_o, ck_n_o}, 1);
    check(stall_o == 1'b1, "R1 reset stall", stall_o, 1);
    rst = 1'b0;
    begin
      int r0;
      r0 = rise_cnt;
      repeat (10) @(negedge clk);
      check(rise_cnt - r0 >= 4, "R1 clock runs after reset", rise_cnt - r0, 4);
    end

    // each command alone, then stop, then restart
    for (int c = 1; c <= 6; c++) begin
      stop_req_i = 1'b0;
      issue(3'(c));
      stop_req_i = 1'b1;
      @(negedge clk);
      check(stall_o == 1'b1, "R8 stall with stop request", stall_o, 1);
      wait_park("R3 park reached");
    end

    // CKE low blocks the stop
    stop_req_i = 1'b0;
    repeat (6) @(negedge clk);
    cke_i = 1'b0;
    stop_req_i = 1'b1;
    begin
      int r0;
      r0 = rise_cnt;
      repeat (40) @(negedge clk);
      check(rise_cnt - r0 >= 15, "R5 clock runs with CKE low", rise_cnt - r0, 15);
      check(!parked, "R5 no park with CKE low", parked, 0);
    end
    cke_i = 1'b1;
    wait_park("R5 park after CKE high");

    // back-to-back mixed burst after restart
    stop_req_i = 1'b0;
    issue(3'd1); issue(3'd2); issue(3'd2); issue(3'd3);
    issue(3'd4); issue(3'd6); issue(3'd5); issue(3'd1);
    stop_req_i = 1'b1;
    wait_park("R3 park after burst");
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 all commands delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule